// File: doc/BRIEF.md
# Request Stream Protocol Monitor

A passive checker that sits beside a wide AXI4-Stream request channel carrying PCIe transaction-layer packets from user logic into a core. It never drives the channel. It watches the data bus, its Dword keep mask, the end flag, the handshake pair and a set of sideband fields: first and last byte enables, per-packet address offsets, start and end markers, the lane pointer of the first start, a discontinue flag and per-byte parity. A side input supplies the Dword length of each packet that starts in a beat, so the monitor does not have to parse headers.

Each protocol rule owns one bit of an error vector. When a rule is broken, `err_pulse` shows that bit for exactly the offending cycle, and `err_sticky` keeps it until reset. A separate level output, `pkt_null`, marks a packet that the core will drop because discontinue was seen on one of its accepted beats. A parameter selects between a plain mode, where packets are framed by the end flag, and a straddled mode, where up to four packets share a beat and are framed only by the start and end markers.

Error bit positions: 0 hold, 1 valid gap, 2 keep shape, 3 discontinue on first beat, 4 discontinue without valid, 5 start beside discontinued end, 6 parity, 7 nonzero offset, 8 last byte enable on short request, 9 start lane, 10 orphan end, 11 start while open.

Top module: `rqs_proto_monitor`

## Requirements
- R1: While reset is low, and at the first edge after its release, `err_sticky` is all zeros and `pkt_null` is 0.
- R2: After a cycle with tvalid high and tready low, the next cycle must have tvalid high and every data and sideband input unchanged, otherwise bit 0 pulses.
- R3: While a packet is open (an accepted beat has started it and its closing beat has not been accepted), a cycle with tvalid low pulses bit 1.
- R4: In plain mode an accepted beat with the end flag low must have every keep bit set, and an accepted beat with the end flag high must have a nonzero keep mask whose ones run contiguously from bit 0; otherwise bit 2 pulses.
- R5: Discontinue on an accepted beat that begins with no packet open pulses bit 3; discontinue while tvalid is low pulses bit 4.
- R6: `pkt_null` rises in the cycle after an accepted beat with discontinue high that does not close the packet, stays high on later beats even if discontinue drops, and falls in the cycle after the closing beat is accepted.
- R7: In straddled mode the end flag and keep mask are ignored and packets are framed only by the start bits (sop[3:0]) and end bits (eop[3:0]), both filled from bit 0 upward; an accepted beat with discontinue high, any end bit and any start bit pulses bit 5.
- R8: With parity checking enabled, parity bit i must equal the odd parity of byte i of tdata (the bit that makes the nine bits hold an odd count of ones) on every accepted beat, otherwise bit 6 pulses.
- R9: For each packet starting in an accepted beat (slot k uses addr_off[4k+3:4k], last_be[4k+3:4k] and req_len[11k+10:11k]), in Dword-aligned mode a nonzero offset pulses bit 7, and a length of 0 or 1 Dword with a nonzero last byte enable pulses bit 8.
- R10: In straddled mode an accepted beat that starts a packet while no packet is open must have sop0_ptr equal to 0, otherwise bit 9 pulses.
- R11: In straddled mode, with open = 1 if a packet is open at the start of a beat, an accepted beat where open + starts - ends is below 0 pulses bit 10, and above 1 pulses bit 11.
- R12: Every bit that pulses is set in `err_sticky` from the next cycle on, and no bit of `err_sticky` clears before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdata | input | DWORDS*32 | Request data bus |
| tkeep | input | DWORDS | Dword keep mask |
| tlast | input | 1 | End-of-packet flag (plain mode) |
| tvalid | input | 1 | Source valid |
| tready | input | 1 | Sink ready |
| first_be | input | SLOTS*4 | First byte enables, four bits per packet slot |
| last_be | input | SLOTS*4 | Last byte enables, four bits per packet slot |
| addr_off | input | SLOTS*4 | Payload offset in Dwords, four bits per slot |
| sop | input | SLOTS | Start markers, bit k for the k-th start in the beat |
| sop0_ptr | input | 2 | Lane of the first start in the beat |
| eop | input | SLOTS | End markers, bit k for the k-th end in the beat |
| disc | input | 1 | Discontinue flag |
| parity | input | DWORDS*4 | Odd parity per data byte |
| req_len | input | SLOTS*LEN_W | Dword length of each starting packet |
| err_pulse | output | 12 | Violations in the current cycle |
| err_sticky | output | 12 | Violations seen since reset |
| pkt_null | output | 1 | Current packet is being nullified |

## Verification
The case where two functions meet in one cycle is a straddled beat in which an open packet ends with discontinue high while a new packet starts: the start-beside-discontinue rule fires while the open-packet bookkeeping counts one end and one start in the same beat. The bench opens a packet, then sends a beat with one start bit, one end bit and discontinue high, and expects bit 5 alone, with no orphan-end, over-open, first-beat or lane pulse. A second meeting point is the pulse and the sticky vector: consecutive violations of different rules must accumulate, and a clean beat after them must leave both bits set while the pulse returns to zero.

// File: rtl/rqs_proto_monitor.sv
module rqs_proto_monitor #(
  parameter int DWORDS        = 8,
  parameter int SLOTS         = 4,
  parameter int LEN_W         = 11,
  parameter bit STRADDLE      = 1'b0,
  parameter bit PARITY_EN     = 1'b1,
  parameter bit DWORD_ALIGNED = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DWORDS*32-1:0]     tdata,
  input  logic [DWORDS-1:0]        tkeep,
  input  logic                     tlast,
  input  logic                     tvalid,
  input  logic                     tready,
  input  logic [SLOTS*4-1:0]       first_be,
  input  logic [SLOTS*4-1:0]       last_be,
  input  logic [SLOTS*4-1:0]       addr_off,
  input  logic [SLOTS-1:0]         sop,
  input  logic [1:0]               sop0_ptr,
  input  logic [SLOTS-1:0]         eop,
  input  logic                     disc,
  input  logic [DWORDS*4-1:0]      parity,
  input  logic [SLOTS*LEN_W-1:0]   req_len,
  output logic [11:0]              err_pulse,
  output logic [11:0]              err_sticky,
  output logic                     pkt_null
);
  localparam int BYTES  = DWORDS * 4;
  localparam int BEAT_W = DWORDS*32 + DWORDS + 1 + 14*SLOTS + 3 + BYTES;
  localparam logic [DWORDS-1:0] KEEP_ONE = DWORDS'(1);

  logic              acc, first_beat, closing, open_nxt;
  logic              stall_q, open_q, abort_q;
  logic [BEAT_W-1:0] beat_now, snap_q;
  logic [SLOTS-1:0]  starts, off_bad, lbe_bad;
  logic [BYTES-1:0]  par_bad;
  logic              keep_err, dsop_err, lane_err, orphan_err, over_err;

  assign acc        = tvalid & tready;
  assign first_beat = acc & ~open_q;
  assign beat_now   = {tdata, tkeep, tlast, first_be, last_be, addr_off,
                       sop, sop0_ptr, eop, disc, parity};

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign off_bad[k] = addr_off[4*k +: 4] != 4'd0;
    assign lbe_bad[k] = (req_len[LEN_W*k +: LEN_W] <= LEN_W'(1)) &&
                        (last_be[4*k +: 4] != 4'd0);
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_par
    assign par_bad[i] = parity[i] != ~^tdata[8*i +: 8];
  end

  if (STRADDLE) begin : g_strad
    logic [2:0]        ns, ne;
    logic signed [4:0] tot;
    always_comb begin
      ns = '0;
      ne = '0;
      for (int k = 0; k < SLOTS; k++) begin
        ns = ns + 3'(sop[k]);
        ne = ne + 3'(eop[k]);
      end
    end
    assign tot        = $signed({4'b0, open_q}) + $signed({2'b0, ns}) - $signed({2'b0, ne});
    assign starts     = acc ? sop : '0;
    assign open_nxt   = acc ? (tot > 5'sd0) : open_q;
    assign closing    = acc & (|eop) & ~(tot > 5'sd0);
    assign keep_err   = 1'b0;
    assign dsop_err   = acc & disc & (|eop) & (|sop);
    assign lane_err   = acc & ~open_q & (|sop) & (sop0_ptr != 2'd0);
    assign orphan_err = acc & (tot < 5'sd0);
    assign over_err   = acc & (tot > 5'sd1);
  end else begin : g_plain
    assign starts     = first_beat ? SLOTS'(1) : '0;
    assign open_nxt   = acc ? ~tlast : open_q;
    assign closing    = acc & tlast;
    assign keep_err   = acc & (tlast ? (tkeep == '0 || (tkeep & (tkeep + KEEP_ONE)) != '0)
                                     : (tkeep != '1));
    assign dsop_err   = 1'b0;
    assign lane_err   = 1'b0;
    assign orphan_err = 1'b0;
    assign over_err   = 1'b0;
  end

  assign err_pulse[0]  = stall_q & (~tvalid | (beat_now != snap_q));
  assign err_pulse[1]  = open_q & ~tvalid;
  assign err_pulse[2]  = keep_err;
  assign err_pulse[3]  = first_beat & disc;
  assign err_pulse[4]  = disc & ~tvalid;
  assign err_pulse[5]  = dsop_err;
  assign err_pulse[6]  = PARITY_EN & acc & (|par_bad);
  assign err_pulse[7]  = DWORD_ALIGNED & (|(off_bad & starts));
  assign err_pulse[8]  = |(lbe_bad & starts);
  assign err_pulse[9]  = lane_err;
  assign err_pulse[10] = orphan_err;
  assign err_pulse[11] = over_err;

  assign pkt_null = abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q    <= 1'b0;
      snap_q     <= '0;
      open_q     <= 1'b0;
      abort_q    <= 1'b0;
      err_sticky <= '0;
    end else begin
      stall_q    <= tvalid & ~tready;
      snap_q     <= beat_now;
      open_q     <= open_nxt;
      err_sticky <= err_sticky | err_pulse;
      if (acc) abort_q <= closing ? 1'b0 : (abort_q | disc);
    end
  end
endmodule

// File: rtl/rqs_proto_monitor_chk.sv
module rqs_proto_monitor_chk #(
  parameter int DWORDS   = 8,
  parameter bit STRADDLE = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tvalid,
  input logic              tready,
  input logic              tlast,
  input logic [DWORDS-1:0] tkeep,
  input logic              disc,
  input logic [11:0]       err_pulse,
  input logic [11:0]       err_sticky,
  input logic              pkt_null
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (err_sticky == '0 && !pkt_null));

  a_r2_stall_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> (tvalid || err_pulse[0]));

  a_r5_disc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (disc && !tvalid) |-> err_pulse[4]);

  a_r6_null_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_null) |-> $past(disc && tvalid && tready));

  a_r12_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

  a_r12_pulse_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |=> ((err_sticky & $past(err_pulse)) == $past(err_pulse)));

  if (!STRADDLE) begin : g_plain_chk
    a_r4_keep_full: assert property (@(posedge clk) disable iff (!rst_n)
      (tvalid && tready && !tlast && tkeep != '1) |-> err_pulse[2]);
  end
endmodule

bind rqs_proto_monitor rqs_proto_monitor_chk #(.DWORDS(DWORDS), .STRADDLE(STRADDLE)) chk_i (
  .clk(clk), .rst_n(rst_n), .tvalid(tvalid), .tready(tready), .tlast(tlast),
  .tkeep(tkeep), .disc(disc), .err_pulse(err_pulse), .err_sticky(err_sticky),
  .pkt_null(pkt_null)
);

// File: tb/rqs_proto_monitor_tb.sv
module rqs_proto_monitor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [255:0] tdata;
  logic [7:0]   tkeep;
  logic         tlast, tvalid, tready, disc;
  logic [15:0]  first_be, last_be, addr_off;
  logic [3:0]   sop, eop;
  logic [1:0]   sop0_ptr;
  logic [31:0]  parity, par_flip;
  logic [43:0]  req_len;
  logic [11:0]  pulse_n, sticky_n, pulse_s, sticky_s;
  logic         null_n, null_s;
  logic [11:0]  cap_n, cap_s;
  logic         cap_null;

  int n_chk = 0;
  int n_bad = 0;

  always_comb
    for (int i = 0; i < 32; i++) parity[i] = (~^tdata[8*i +: 8]) ^ par_flip[i];

  rqs_proto_monitor #(.STRADDLE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .tdata(tdata), .tkeep(tkeep), .tlast(tlast),
    .tvalid(tvalid), .tready(tready), .first_be(first_be), .last_be(last_be),
    .addr_off(addr_off), .sop(sop), .sop0_ptr(sop0_ptr), .eop(eop), .disc(disc),
    .parity(parity), .req_len(req_len), .err_pulse(pulse_n),
    .err_sticky(sticky_n), .pkt_null(null_n));

  rqs_proto_monitor #(.STRADDLE(1'b1)) dut_st (
    .clk(clk), .rst_n(rst_n), .tdata(tdata), .tkeep(tkeep), .tlast(tlast),
    .tvalid(tvalid), .tready(tready), .first_be(first_be), .last_be(last_be),
    .addr_off(addr_off), .sop(sop), .sop0_ptr(sop0_ptr), .eop(eop), .disc(disc),
    .parity(parity), .req_len(req_len), .err_pulse(pulse_s),
    .err_sticky(sticky_s), .pkt_null(null_s));

  typedef struct packed {
    logic [7:0]  keep;
    logic        last;
    logic        dsc;
    logic [3:0]  off;
    logic [3:0]  lbe;
    logic [10:0] len;
    logic        flip;
    logic [11:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'hff, 1'b1, 1'b0, 4'd0, 4'h0, 11'd4, 1'b0, 12'h000},
    '{8'h0f, 1'b1, 1'b0, 4'd0, 4'h0, 11'd4, 1'b0, 12'h000},
    '{8'h0d, 1'b1, 1'b0, 4'd0, 4'h0, 11'd4, 1'b0, 12'h004},
    '{8'h7f, 1'b0, 1'b0, 4'd0, 4'h0, 11'd4, 1'b0, 12'h004},
    '{8'h00, 1'b1, 1'b0, 4'd0, 4'h0, 11'd4, 1'b0, 12'h004},
    '{8'hff, 1'b1, 1'b1, 4'd0, 4'h0, 11'd4, 1'b0, 12'h008},
    '{8'hff, 1'b1, 1'b0, 4'd3, 4'h0, 11'd4, 1'b0, 12'h080},
    '{8'hff, 1'b1, 1'b0, 4'd0, 4'hf, 11'd1, 1'b0, 12'h100},
    '{8'hff, 1'b1, 1'b0, 4'd0, 4'hf, 11'd4, 1'b0, 12'h000},
    '{8'hff, 1'b1, 1'b0, 4'd0, 4'h0, 11'd4, 1'b1, 12'h040}
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    tdata = 256'h0; tkeep = 8'hff; tlast = 1'b1; tvalid = 1'b0; tready = 1'b1;
    disc = 1'b0; first_be = 16'h000f; last_be = 16'h0; addr_off = 16'h0;
    sop = 4'h0; eop = 4'h0; sop0_ptr = 2'd0; par_flip = 32'h0; req_len = 44'd4;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic cyc();
    #4;
    cap_n = pulse_n; cap_s = pulse_s; cap_null = null_n;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    #2;
    check(sticky_n, 0, "R1 sticky during reset");
    do_reset();
    check(sticky_n, 0, "R1 sticky after reset");
    check(null_n, 0, "R1 null after reset");

    foreach (VECS[j]) begin
      do_reset();
      tvalid = 1'b1; tkeep = VECS[j].keep; tlast = VECS[j].last; disc = VECS[j].dsc;
      addr_off = {12'h0, VECS[j].off}; last_be = {12'h0, VECS[j].lbe};
      req_len = {33'h0, VECS[j].len}; par_flip = {31'h0, VECS[j].flip};
      tdata = {8{32'h3c5a_0000 + 32'(j)}};
      cyc();
      check(cap_n, VECS[j].exp, $sformatf("R4/R5/R8/R9 vec %0d pulse", j));
      check(sticky_n, VECS[j].exp, $sformatf("R12 vec %0d sticky", j));
    end

    do_reset();
    tvalid = 1'b1; tready = 1'b0; tdata = 256'h1234;
    cyc();
    check(cap_n, 0, "R2 first stall cycle");
    tdata = 256'h5678;
    cyc();
    check(cap_n[0], 1, "R2 data changed during stall");
    do_reset();
    tvalid = 1'b1; tready = 1'b0; disc = 1'b0; tdata = 256'h9;
    cyc();
    tready = 1'b1;
    cyc();
    check(cap_n, 0, "R2 stable hold then accept");

    do_reset();
    tvalid = 1'b1; tlast = 1'b0;
    cyc();
    check(cap_n, 0, "R3 opening beat");
    tvalid = 1'b0;
    cyc();
    check(cap_n, 12'h002, "R3 valid gap inside packet");

    do_reset();
    disc = 1'b1;
    cyc();
    check(cap_n, 12'h010, "R5 discontinue without valid");

    do_reset();
    tvalid = 1'b1; tlast = 1'b0;
    cyc();
    check(cap_null, 0, "R6 null before discontinue");
    disc = 1'b1;
    cyc();
    check(cap_n, 0, "R5 discontinue mid packet allowed");
    check(cap_null, 0, "R6 null not yet raised");
    disc = 1'b0; tlast = 1'b1; tkeep = 8'h03;
    cyc();
    check(cap_null, 1, "R6 null held after discontinue drops");
    tvalid = 1'b0;
    cyc();
    check(cap_null, 0, "R6 null cleared after closing beat");

    do_reset();
    tvalid = 1'b1; sop = 4'b0001; eop = 4'b0001; tlast = 1'b0; tkeep = 8'h00;
    cyc();
    check(cap_s, 0, "R7 straddle ignores tlast and tkeep");
    sop = 4'b0001; eop = 4'b0000;
    cyc();
    check(cap_s, 0, "R7 straddle opening beat");
    sop = 4'b0001; eop = 4'b0001; disc = 1'b1;
    cyc();
    check(cap_s, 12'h020, "R7 start beside discontinued end");

    do_reset();
    tvalid = 1'b1; sop = 4'b0001; sop0_ptr = 2'd2;
    cyc();
    check(cap_s, 12'h200, "R10 fresh start off lane 0");

    do_reset();
    tvalid = 1'b1; eop = 4'b0001;
    cyc();
    check(cap_s, 12'h400, "R11 end with no open packet");
    eop = 4'b0000; sop = 4'b0011;
    cyc();
    check(cap_s, 12'h800, "R11 two starts leave two open");
    check(sticky_s, 12'hc00, "R12 sticky accumulates");
    sop = 4'b0000; eop = 4'b0001;
    cyc();
    check(cap_s, 0, "R12 clean beat no pulse");
    check(sticky_s, 12'hc00, "R12 sticky kept after clean beat");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule